// File: doc/BRIEF.md
# UTMI Dual-Mode Data Bus Adapter

This block sits on the transceiver side of a UTMI-style link. It connects the transceiver's internal byte-wide transmit and receive paths to a link controller. A static mode input selects between two pin arrangements.

- **16-bit mode:** one shared 16-bit bus whose direction follows the transmit and receive valid flags. A bidirectional high-byte flag says, for each word, whether bits 15:8 carry data.
- **8-bit mode:** the same 16 pins are split for good. The low half takes transmit bytes in, and the high half carries receive bytes out.

On the transmit side the adapter does the following:

- It opens a packet when the link raises `tx_valid`, and signals packet start downstream.
- It captures each word into a holding register, and acknowledges the capture with `tx_ready`.
- It hands the bytes of each word to the line side, low byte first.
- It signals packet end once `tx_valid` drops and the holding register is empty.

On the receive side the adapter does the following:

- It pairs incoming bytes into words in 16-bit mode. A lone final byte is presented with the high-byte flag low.
- It raises `rx_valid` when the receive holding register is full.
- It tracks the packet on `rx_active`, and passes errors out on `rx_error` with the same register delay as the data.

The mode input is sampled only while no transfer is in flight. A transmit request that arrives during an active receive packet waits until that packet is over.

Top module: `utmi_bus_adapter`

## Requirements
- R1: While `rst_n` is low, the following outputs are 0: `tx_ready`, `rx_valid`, `rx_active`, `rx_error`, `line_tx_valid`, `line_tx_start`, `line_tx_end`, `hi_oe` and `bus_oe`. The adapter leaves reset in 16-bit mode.
- R2: In 16-bit mode, `bus_oe` depends on the two valid flags:
  - It is 16'h0000 and `hi_oe` is 0 whenever `tx_valid` is 1.
  - It is 16'hFFFF and `hi_oe` is 1 when `tx_valid` is 0 and `rx_valid` is 1.
  - It is 16'h0000 when both are 0.
- R3: In 8-bit mode, `bus_oe` is fixed at 16'hFF00 and `hi_oe` is 0. Transmit bytes come from `bus_in[7:0]` only, and `bus_in[15:8]` and `hi_in` have no effect on the bytes sent.
- R4: In a cycle where no packet is open, `tx_valid` is 1 and `rx_active` is 0, `line_tx_start` is 1 for that cycle, and the packet is open from the next cycle.
- R5: `tx_ready` is 1 exactly when all four of these hold:
  - a packet is open;
  - `tx_valid` is 1;
  - the holding register is empty, or holds one byte that `line_tx_ready` accepts in the same cycle;
  - the word on `bus_in` is captured at that clock edge.
- R6: Transmit bytes appear on `line_tx_byte` with `line_tx_valid` from the cycle after capture, and each leaves when `line_tx_ready` is 1. In 16-bit mode a word with `hi_in` = 1 yields bits 7:0 and then bits 15:8, and `tx_ready` stays 0 until the second byte is accepted. A word with `hi_in` = 0 yields bits 7:0 only.
- R7: After `tx_valid` falls, `line_tx_end` is 1 for one cycle, in the first cycle in which the holding register is empty. The packet is then closed.
- R8: In 16-bit mode, received bytes are paired with the first byte in bits 7:0. `rx_valid` is 1 and `hi_out` is 1 in the cycle after the second byte arrives. A held single byte is presented in bits 7:0 with `hi_out` = 0, in the cycle after `line_rx_active` is seen low.
- R9: In 8-bit mode, each received byte appears on `bus_out[15:8]` with `rx_valid` = 1 in the cycle after it arrives.
- R10: `rx_active` equals the previous cycle's `line_rx_active`, extended for the one extra cycle in which a held single byte is presented.
- R11: `rx_error` equals the previous cycle's `line_rx_error`.
- R12: While `rx_active` is 1, a high `tx_valid` opens no packet: `line_tx_start` and `tx_ready` stay 0. The packet opens in the first cycle in which `rx_active` is 0.
- R13: The mode follows `bus_wide` only at clock edges where all of the following hold: no packet is open, `tx_valid` is 0, `rx_active` is 0 and `line_rx_active` is 0. A change made during a transfer takes effect after the first such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wide | input | 1 | Requested mode: 1 = 16-bit shared bus, 0 = split 8-bit halves |
| tx_valid | input | 1 | Link transmit valid, framing a packet |
| tx_ready | output | 1 | Word on bus_in captured at this edge |
| bus_in | input | 16 | Data pins, input side |
| bus_out | output | 16 | Data pins, output side |
| bus_oe | output | 16 | Per-pin output enable for the data pins |
| hi_in | input | 1 | High-byte-valid flag from the link (transmit, 16-bit mode) |
| hi_out | output | 1 | High-byte-valid flag to the link (receive, 16-bit mode) |
| hi_oe | output | 1 | Output enable for the high-byte flag pin |
| rx_valid | output | 1 | Receive holding register full and presented |
| rx_active | output | 1 | Receive packet in progress |
| rx_error | output | 1 | Receive error, registered |
| line_tx_byte | output | 8 | Byte to the line transmitter |
| line_tx_valid | output | 1 | line_tx_byte is valid |
| line_tx_ready | input | 1 | Line transmitter takes the byte |
| line_tx_start | output | 1 | One-cycle packet-start pulse (start of SYNC) |
| line_tx_end | output | 1 | One-cycle packet-end pulse (start of EOP) |
| line_rx_byte | input | 8 | Byte from the line receiver |
| line_rx_valid | input | 1 | line_rx_byte is valid |
| line_rx_active | input | 1 | Line receiver is inside a packet |
| line_rx_error | input | 1 | Line receiver error flag |

## Verification
Some transmit-side results are combinational in the current cycle's inputs and state, so the bench checks them in the same cycle as the stimulus. These are `tx_ready`, `line_tx_start` and `line_tx_end`. A captured word's first byte is due on `line_tx_byte` one cycle after the capturing edge. `rx_valid`, `bus_out`, `hi_out`, `rx_active` and `rx_error` are due one cycle after the line-side event that causes them. A mode request lands one cycle after the first idle edge. The bench drives every input just after the falling edge and samples 1 ns later. Its reference model predicts the values for that cycle from its own state and the live inputs, and only then advances that state across the coming rising edge. Each prediction is therefore compared in the exact cycle it is due.

// File: rtl/utmi_pkg.sv
package utmi_pkg;

  typedef enum logic {
    TXS_IDLE = 1'b0,
    TXS_OPEN = 1'b1
  } tx_state_e;

  // Number of line bytes a captured link word turns into.
  function automatic logic [1:0] word_byte_count(input logic wide, input logic hi_valid);
    return (wide && hi_valid) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/utmi_tx_path.sv
module utmi_tx_path
  import utmi_pkg::*;
#(
  parameter int unsigned BW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide,
  input  logic              tx_valid,
  input  logic [2*BW-1:0]   word_in,
  input  logic              hi_valid,
  input  logic              rx_busy,
  input  logic              byte_ready,
  output logic              tx_ready,
  output logic              byte_valid,
  output logic [BW-1:0]     byte_data,
  output logic              pkt_start,
  output logic              pkt_end,
  output logic              tx_idle
);
  localparam int unsigned WW = 2 * BW;

  tx_state_e       state_q;
  logic [WW-1:0]   hold_q;
  logic [1:0]      pend_q;
  logic            is_open;
  logic            byte_fire;
  logic            word_load;

  assign is_open    = (state_q == TXS_OPEN);
  assign tx_idle    = !is_open;
  assign byte_valid = (pend_q != 2'd0);
  assign byte_data  = hold_q[BW-1:0];
  assign byte_fire  = byte_valid && byte_ready;
  assign tx_ready   = is_open && tx_valid &&
                      ((pend_q == 2'd0) || ((pend_q == 2'd1) && byte_ready));
  assign word_load  = tx_ready;
  assign pkt_start  = !is_open && tx_valid && !rx_busy;
  assign pkt_end    = is_open && !tx_valid && (pend_q == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TXS_IDLE;
    end else if (pkt_start) begin
      state_q <= TXS_OPEN;
    end else if (pkt_end) begin
      state_q <= TXS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      pend_q <= 2'd0;
    end else if (word_load) begin
      hold_q <= mode_wide ? word_in : {{BW{1'b0}}, word_in[BW-1:0]};
      pend_q <= word_byte_count(mode_wide, hi_valid);
    end else if (byte_fire) begin
      hold_q <= hold_q >> BW;
      pend_q <= pend_q - 2'd1;
    end
  end

  // R6: a two-byte word blocks the next capture
  assert_pair_blocks_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == 2'd2) |-> !tx_ready);
  // R6: the high byte follows the low byte
  assert_high_byte_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_fire && pend_q == 2'd2) |=> byte_valid);
  // R4: a fresh packet can take a word at once
  assert_ready_after_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> (!tx_valid || tx_ready));
  // R7: after the end pulse nothing is left to send
  assert_end_leaves_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> (!byte_valid && !tx_ready));
endmodule

// File: rtl/utmi_rx_path.sv
module utmi_rx_path #(
  parameter int unsigned BW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide,
  input  logic              in_active,
  input  logic              in_valid,
  input  logic [BW-1:0]     in_byte,
  input  logic              in_error,
  output logic              rx_valid,
  output logic              rx_active,
  output logic              rx_error,
  output logic [2*BW-1:0]   rx_word,
  output logic              rx_hi_valid
);
  localparam int unsigned WW = 2 * BW;

  logic [BW-1:0] low_q;
  logic          have_low;
  logic          flush_now;

  assign flush_now = mode_wide && !in_active && !in_valid && have_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid    <= 1'b0;
      rx_active   <= 1'b0;
      rx_error    <= 1'b0;
      rx_word     <= '0;
      rx_hi_valid <= 1'b0;
      low_q       <= '0;
      have_low    <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      rx_error  <= in_error;
      rx_active <= in_active || have_low;
      if (mode_wide) begin
        if (in_valid) begin
          if (have_low) begin
            rx_word     <= {in_byte, low_q};
            rx_hi_valid <= 1'b1;
            rx_valid    <= 1'b1;
            have_low    <= 1'b0;
          end else begin
            low_q    <= in_byte;
            have_low <= 1'b1;
          end
        end else if (flush_now) begin
          rx_word     <= {{BW{1'b0}}, low_q};
          rx_hi_valid <= 1'b0;
          rx_valid    <= 1'b1;
          have_low    <= 1'b0;
        end
      end else if (in_valid) begin
        rx_word     <= {in_byte, {(WW-BW){1'b0}}};
        rx_hi_valid <= 1'b0;
        rx_valid    <= 1'b1;
      end
    end
  end

  // R10: presented data is always inside the active window
  assert_valid_inside_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_active);
  // R11: a new line error shows up one cycle later
  assert_error_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_error) |=> rx_error);
  // R8: a lone trailing byte is flushed with the high flag low
  assert_trailing_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |=> (rx_valid && !rx_hi_valid));
endmodule

// File: rtl/utmi_bus_steer.sv
module utmi_bus_steer #(
  parameter int unsigned BW = 8
) (
  input  logic              mode_wide,
  input  logic              tx_valid,
  input  logic              rx_valid,
  input  logic [2*BW-1:0]   rx_word,
  input  logic              rx_hi_valid,
  output logic [2*BW-1:0]   bus_out,
  output logic [2*BW-1:0]   bus_oe,
  output logic              hi_out,
  output logic              hi_oe
);
  localparam int unsigned WW = 2 * BW;

  logic drive_wide;

  assign drive_wide = mode_wide && !tx_valid && rx_valid;
  assign bus_out    = rx_word;
  assign hi_out     = rx_hi_valid;
  assign hi_oe      = drive_wide;

  always_comb begin
    if (mode_wide) begin
      bus_oe = {WW{drive_wide}};
    end else begin
      bus_oe = {{(WW-BW){1'b1}}, {BW{1'b0}}};
    end
  end
endmodule

// File: rtl/utmi_bus_adapter.sv
module utmi_bus_adapter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wide,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [2*BYTE_W-1:0]   bus_in,
  output logic [2*BYTE_W-1:0]   bus_out,
  output logic [2*BYTE_W-1:0]   bus_oe,
  input  logic                  hi_in,
  output logic                  hi_out,
  output logic                  hi_oe,
  output logic                  rx_valid,
  output logic                  rx_active,
  output logic                  rx_error,
  output logic [BYTE_W-1:0]     line_tx_byte,
  output logic                  line_tx_valid,
  input  logic                  line_tx_ready,
  output logic                  line_tx_start,
  output logic                  line_tx_end,
  input  logic [BYTE_W-1:0]     line_rx_byte,
  input  logic                  line_rx_valid,
  input  logic                  line_rx_active,
  input  logic                  line_rx_error
);
  localparam int unsigned WW = 2 * BYTE_W;

  logic          mode_q;
  logic          tx_idle;
  logic          quiet_now;
  logic [WW-1:0] rx_word;
  logic          rx_hi_valid;

  assign quiet_now = tx_idle && !tx_valid && !rx_active && !line_rx_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b1;
    end else if (quiet_now) begin
      mode_q <= bus_wide;
    end
  end

  utmi_tx_path #(.BW(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_q),
    .tx_valid(tx_valid), .word_in(bus_in), .hi_valid(hi_in),
    .rx_busy(rx_active), .byte_ready(line_tx_ready),
    .tx_ready(tx_ready), .byte_valid(line_tx_valid), .byte_data(line_tx_byte),
    .pkt_start(line_tx_start), .pkt_end(line_tx_end), .tx_idle(tx_idle)
  );

  utmi_rx_path #(.BW(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_q),
    .in_active(line_rx_active), .in_valid(line_rx_valid),
    .in_byte(line_rx_byte), .in_error(line_rx_error),
    .rx_valid(rx_valid), .rx_active(rx_active), .rx_error(rx_error),
    .rx_word(rx_word), .rx_hi_valid(rx_hi_valid)
  );

  utmi_bus_steer #(.BW(BYTE_W)) u_steer (
    .mode_wide(mode_q), .tx_valid(tx_valid), .rx_valid(rx_valid),
    .rx_word(rx_word), .rx_hi_valid(rx_hi_valid),
    .bus_out(bus_out), .bus_oe(bus_oe), .hi_out(hi_out), .hi_oe(hi_oe)
  );

  // R2: never drive the shared bus while the link transmits
  assert_no_contention_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && tx_valid) |-> (bus_oe == '0 && !hi_oe));
  // R13: the mode holds while any transfer is in flight
  assert_mode_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_idle || rx_active || line_rx_active) |=> $stable(mode_q));
  // R12: no transmit start over an active receive packet
  assert_tx_deferred_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && tx_idle) |=> !tx_ready);
endmodule

// File: tb/sim_utmi_bus_adapter.sv
`timescale 1ns/1ps
module sim_utmi_bus_adapter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wide = 1'b1;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] bus_in = 16'h0;
  logic [15:0] bus_out, bus_oe;
  logic        hi_in = 1'b0;
  logic        hi_out, hi_oe;
  logic        rx_valid, rx_active, rx_error;
  logic [7:0]  line_tx_byte;
  logic        line_tx_valid;
  logic        line_tx_ready = 1'b0;
  logic        line_tx_start, line_tx_end;
  logic [7:0]  line_rx_byte = 8'h0;
  logic        line_rx_valid = 1'b0;
  logic        line_rx_active = 1'b0;
  logic        line_rx_error = 1'b0;

  always #2.5 clk = ~clk;

  utmi_bus_adapter u0 (.*);

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  // link and line stimulus state
  int          link_left = 0;
  logic [15:0] link_word = 16'h3c5a;
  logic        link_vh = 1'b1;
  int          vh_mode = 1;     // 0 low, 1 high, 2 toggling
  int          rdy_mode = 0;    // 0 always ready, 1 stalls
  int          rx_left = 0;
  int          rx_gap = 0;
  int          rx_sent = 0;
  int          rx_err_at = -1;
  logic [7:0]  rx_next = 8'h40;

  // reference model state
  logic        m_mode = 1'b1;
  logic        m_open = 1'b0;
  logic [7:0]  m_q[$];
  logic        m_rxv = 1'b0, m_rxact = 1'b0, m_rxerr = 1'b0, m_vh = 1'b0;
  logic [15:0] m_word = 16'h0;
  logic        m_have = 1'b0;
  logic [7:0]  m_low = 8'h0;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic tick();
    logic        e_ready, e_start, e_end, e_hioe, fire;
    logic [15:0] e_oe;
    logic        n_rxv, n_vh, n_have;
    logic [15:0] n_word;
    logic [7:0]  n_low;
    string       oe_req;
    // drive this cycle's inputs
    tx_valid       = (link_left > 0);
    bus_in         = link_word;
    hi_in          = link_vh;
    line_tx_ready  = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    line_rx_active = (rx_left > 0);
    line_rx_valid  = (rx_left > 0) && ((cyc % (rx_gap + 1)) == 0);
    line_rx_byte   = rx_next;
    line_rx_error  = line_rx_valid && (rx_sent == rx_err_at);
    #1;
    // expectations for this cycle
    e_ready = m_open && tx_valid && (m_q.size() == 0 || (m_q.size() == 1 && line_tx_ready));
    e_start = !m_open && tx_valid && !m_rxact;
    e_end   = m_open && !tx_valid && (m_q.size() == 0);
    e_oe    = m_mode ? ((!tx_valid && m_rxv) ? 16'hffff : 16'h0000) : 16'hff00;
    e_hioe  = m_mode && !tx_valid && m_rxv;
    oe_req  = (bus_wide != m_mode) ? "R13" : (m_mode ? "R2" : "R3");
    if (tx_valid && m_rxact) begin
      chk("R12", "tx_ready", {15'h0, tx_ready}, {15'h0, e_ready});
      chk("R12", "line_tx_start", {15'h0, line_tx_start}, {15'h0, e_start});
    end else begin
      chk("R5", "tx_ready", {15'h0, tx_ready}, {15'h0, e_ready});
      chk("R4", "line_tx_start", {15'h0, line_tx_start}, {15'h0, e_start});
    end
    chk("R7", "line_tx_end", {15'h0, line_tx_end}, {15'h0, e_end});
    chk("R6", "line_tx_valid", {15'h0, line_tx_valid}, {15'h0, m_q.size() != 0});
    if (m_q.size() != 0)
      chk(m_mode ? "R6" : "R3", "line_tx_byte", {8'h0, line_tx_byte}, {8'h0, m_q[0]});
    chk(oe_req, "bus_oe", bus_oe, e_oe);
    chk(oe_req, "hi_oe", {15'h0, hi_oe}, {15'h0, e_hioe});
    chk(m_mode ? "R8" : "R9", "rx_valid", {15'h0, rx_valid}, {15'h0, m_rxv});
    chk(m_mode ? "R8" : "R9", "bus_out", bus_out & e_oe, m_word & e_oe);
    if (e_hioe) chk("R8", "hi_out", {15'h0, hi_out}, {15'h0, m_vh});
    chk("R10", "rx_active", {15'h0, rx_active}, {15'h0, m_rxact});
    chk("R11", "rx_error", {15'h0, rx_error}, {15'h0, m_rxerr});
    // advance the model across the coming edge
    fire = (m_q.size() != 0) && line_tx_ready;
    if (fire) void'(m_q.pop_front());
    if (e_ready) begin
      m_q.push_back(bus_in[7:0]);
      if (m_mode && hi_in) m_q.push_back(bus_in[15:8]);
    end
    n_rxv = 1'b0; n_vh = m_vh; n_word = m_word; n_have = m_have; n_low = m_low;
    if (m_mode) begin
      if (line_rx_valid) begin
        if (m_have) begin n_word = {line_rx_byte, m_low}; n_vh = 1'b1; n_rxv = 1'b1; n_have = 1'b0; end
        else begin n_low = line_rx_byte; n_have = 1'b1; end
      end else if (!line_rx_active && m_have) begin
        n_word = {8'h00, m_low}; n_vh = 1'b0; n_rxv = 1'b1; n_have = 1'b0;
      end
    end else if (line_rx_valid) begin
      n_word = {line_rx_byte, 8'h00}; n_vh = 1'b0; n_rxv = 1'b1;
    end
    if (!m_open && !tx_valid && !m_rxact && !line_rx_active) m_mode = bus_wide;
    if (e_start) m_open = 1'b1;
    if (e_end) m_open = 1'b0;
    m_rxact = line_rx_active || m_have;
    m_rxerr = line_rx_error;
    m_rxv = n_rxv; m_vh = n_vh; m_word = n_word; m_have = n_have; m_low = n_low;
    // advance the stimulus automata
    if (e_ready) begin
      link_left--;
      link_word = link_word * 16'd13 + 16'h2b5;
      if (vh_mode == 2) link_vh = ~link_vh;
      else link_vh = (vh_mode == 1);
    end
    if (line_rx_valid) begin
      rx_left--; rx_sent++; rx_next = rx_next + 8'h17;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send(input int words, input int vh, input int rdy);
    vh_mode = vh; rdy_mode = rdy;
    link_vh = (vh != 0);
    link_left = words;
  endtask

  task automatic recv(input int bytes, input int gap, input int err_at);
    rx_gap = gap; rx_sent = 0; rx_err_at = err_at; rx_left = bytes;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs at rest while reset is held
    chk("R1", "tx_ready", {15'h0, tx_ready}, 16'h0);
    chk("R1", "rx_valid", {15'h0, rx_valid}, 16'h0);
    chk("R1", "rx_active", {15'h0, rx_active}, 16'h0);
    chk("R1", "rx_error", {15'h0, rx_error}, 16'h0);
    chk("R1", "line_tx_valid", {15'h0, line_tx_valid}, 16'h0);
    chk("R1", "start_end", {14'h0, line_tx_start, line_tx_end}, 16'h0);
    chk("R1", "bus_oe", bus_oe, 16'h0);
    chk("R1", "hi_oe", {15'h0, hi_oe}, 16'h0);
    rst_n = 1'b1;
    run(4);
    send(4, 2, 0); run(16);            // wide transmit, mixed widths
    send(5, 1, 1); run(30);            // wide transmit, stalled line
    recv(6, 0, 3); run(12);            // wide receive, even count, one error
    recv(5, 1, -1); run(18);           // wide receive, trailing single byte
    recv(6, 1, -1); run(2);            // receive, then a transmit request over it
    send(3, 1, 0); run(30);
    send(4, 2, 1); run(2);             // mode change requested mid-packet
    bus_wide = 1'b0; run(25);
    send(3, 2, 0); run(16);            // narrow transmit, upper bits and flag ignored
    recv(4, 0, 1); run(10);            // narrow receive
    recv(3, 2, -1); run(14);
    bus_wide = 1'b1; run(4);
    recv(3, 0, -1); run(10);           // back to wide, odd count
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule